// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a supervision counter that software must service at regular intervals. A low-speed tick advances the counter, and the count period is one of eight lengths chosen by a 3-bit select. If software fails to clear the counter before it reaches the end of the period, the block first raises an interrupt and then, on a second overflow, requests a system reset. When the optional clear window is turned on, the block is stricter. Software may clear the counter only in the late part of the period, and any overflow leads straight to a reset.

A clear that arrives too early is treated as a sign of runaway code and also requests a reset. The reset request carries a 2-bit cause code. It stays asserted, with the counter frozen, until the reset network acknowledges it. The live count value is always visible on an output port so that software can read it. A static enable input turns the entire function on or off.

Top module: `watchdog_win`

## Requirements
- R1: After reset, `count` is 0, `irq` is 0, `rst_req` is 0 and `rst_cause` is 0.
- R2: While enabled and not in a reset request, each cycle with `tick` high adds one to `count`, and cycles without `tick` leave it unchanged. `count` always shows the live counter value.
- R3: `period_sel` codes 0 to 7 select periods of 2^8, 2^9, 2^10, 2^11, 2^12, 2^14, 2^16 and 2^18 ticks. A tick at count period-1 is an overflow, and the counter wraps to 0.
- R4: With the window off, an overflow while no earlier overflow is pending gives a one-cycle `irq` pulse in the cycle after that tick, with no reset request, and counting goes on from 0.
- R5: With the window off, an overflow while an earlier overflow is still pending raises `rst_req` with cause 2'b01 (overflow).
- R6: A permitted clear (`clr_req` high for one cycle) returns `count` to 0 and drops any pending first overflow, so the next overflow gives an interrupt again.
- R7: With `win_on` high, a clear is permitted only when count >= period/2 (`win_size`=0) or count >= period/4 (`win_size`=1). An earlier clear raises `rst_req` with cause 2'b10 (invalid clear) and sets `count` to 0. With `win_on` low, every clear is permitted.
- R8: With `win_on` high, the first overflow raises `rst_req` with cause 2'b01 directly, and `irq` stays low.
- R9: Once raised, `rst_req` and `rst_cause` hold, and `count` stays at 0, with ticks and clears ignored, until `rst_ack` is high for a cycle. The block then drops `rst_req`, returns the cause to 2'b00 and counts again from 0. The cause is non-zero exactly when `rst_req` is high.
- R10: With `wd_en` low, `count` stays 0, and no interrupt or reset request is produced, whatever the tick and clear inputs do.
- R11: A permitted clear in the same cycle as the overflow tick wins. The counter goes to 0 with no interrupt and no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wd_en | input | 1 | Static enable of the whole watchdog |
| tick | input | 1 | Count-clock enable, one pulse per count step |
| clr_req | input | 1 | Software clear strobe |
| period_sel | input | 3 | Overflow period code |
| win_on | input | 1 | Clear window enable |
| win_size | input | 1 | Window size: 0 = final half, 1 = final three quarters |
| rst_ack | input | 1 | Acknowledge that releases a reset request |
| irq | output | 1 | First-overflow interrupt pulse |
| rst_req | output | 1 | Held reset request |
| rst_cause | output | 2 | 00 none, 01 overflow, 10 invalid clear |
| count | output | 18 | Live counter value |

## Verification
The bench clears the counter exactly one tick below and exactly at each window threshold. A design with an off-by-one compare either resets the system on a legal clear or lets an early clear through. It also issues a clear in the same cycle as the terminal tick. A design with the wrong priority there raises a spurious interrupt or reset. The bench lets two overflows pass with the window off and one with it on, which exposes designs that skip the interrupt stage or escalate in the wrong mode. It also sends clears and ticks during a held reset request, which exposes a request that leaks away or a counter that keeps running. Period code 5 checks that the select decodes the non-contiguous exponent list rather than a linear one.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   typedef enum logic [1:0] {
      CAUSE_NONE   = 2'b00,
      CAUSE_OVF    = 2'b01,
      CAUSE_BADCLR = 2'b10
   } wdt_cause_e;

   localparam int EXP_W = 5;

endpackage

// File: rtl/wdt_count.sv
module wdt_count #(
   parameter int CNT_W = 18,
   parameter int NPER  = 8,
   parameter logic [NPER-1:0][4:0] PER_EXP = '0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     en,
   input  logic                     tick,
   input  logic [$clog2(NPER)-1:0]  sel,
   input  logic                     clr,
   input  logic                     hold,
   input  logic                     restart,
   output logic [CNT_W-1:0]         count,
   output logic                     wrap
);

   logic [CNT_W-1:0] last_t [NPER];
   logic             at_last;

   for (genvar i = 0; i < NPER; i++) begin : g_last
      localparam logic [CNT_W:0] FULL  = (CNT_W+1)'(1) << PER_EXP[i];
      localparam logic [CNT_W:0] LASTW = FULL - (CNT_W+1)'(1);
      assign last_t[i] = LASTW[CNT_W-1:0];
   end

   assign at_last = (count == last_t[sel]);
   assign wrap    = en && tick && !hold && at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (!en || restart || clr) begin
         count <= '0;
      end else if (hold) begin
         count <= count;
      end else if (tick) begin
         count <= at_last ? '0 : count + CNT_W'(1);
      end
   end

   // R2: no tick, no clear, no restart -> value kept
   p_hold_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !tick && !clr && !restart) |=> $stable(count));

   // R3: an overflow wraps the counter to zero
   p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (count == '0));

   // R10: disabled watchdog keeps the counter cleared
   p_off_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (count == '0));

endmodule

// File: rtl/wdt_window.sv
module wdt_window #(
   parameter int CNT_W = 18,
   parameter int NPER  = 8,
   parameter logic [NPER-1:0][4:0] PER_EXP = '0,
   parameter bit THR_TABLE = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [$clog2(NPER)-1:0]  sel,
   input  logic                     win_on,
   input  logic                     win_size,
   input  logic                     en,
   input  logic                     hold,
   input  logic                     clr_req,
   input  logic [CNT_W-1:0]         count,
   output logic                     ok_clr,
   output logic                     bad_clr
);

   logic [CNT_W-1:0] thr;
   logic             allowed;
   logic             live;

   if (THR_TABLE) begin : g_table
      logic [CNT_W-1:0] half_t [NPER];
      logic [CNT_W-1:0] qtr_t  [NPER];
      for (genvar i = 0; i < NPER; i++) begin : g_ent
         localparam logic [CNT_W:0] FULL = (CNT_W+1)'(1) << PER_EXP[i];
         localparam logic [CNT_W:0] HALF = FULL >> 1;
         localparam logic [CNT_W:0] QTR  = FULL >> 2;
         assign half_t[i] = HALF[CNT_W-1:0];
         assign qtr_t[i]  = QTR[CNT_W-1:0];
      end
      assign thr = win_size ? qtr_t[sel] : half_t[sel];
   end else begin : g_shift
      logic [CNT_W:0] full;
      logic [CNT_W:0] half;
      logic [CNT_W:0] qtr;
      assign full = (CNT_W+1)'(1) << PER_EXP[sel];
      assign half = full >> 1;
      assign qtr  = full >> 2;
      assign thr  = win_size ? qtr[CNT_W-1:0] : half[CNT_W-1:0];
   end

   assign allowed = !win_on || (count >= thr);
   assign live    = en && !hold && clr_req;
   assign ok_clr  = live && allowed;
   assign bad_clr = live && !allowed;

   // R7: an open window never rejects a clear
   p_open_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (live && !win_on) |-> ok_clr);

   // R9: clears during a held request are ignored
   p_hold_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
      hold |-> (!ok_clr && !bad_clr));

endmodule

// File: rtl/wdt_escal.sv
module wdt_escal
   import wdt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       ovf,
   input  logic       ok_clr,
   input  logic       bad_clr,
   input  logic       win_on,
   input  logic       ack,
   output logic       irq,
   output logic       rst_q,
   output wdt_cause_e cause,
   output logic       restart
);

   logic pending;

   assign restart = rst_q && ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq     <= 1'b0;
         rst_q   <= 1'b0;
         cause   <= CAUSE_NONE;
         pending <= 1'b0;
      end else if (!en) begin
         irq     <= 1'b0;
         rst_q   <= 1'b0;
         cause   <= CAUSE_NONE;
         pending <= 1'b0;
      end else if (rst_q) begin
         irq <= 1'b0;
         if (ack) begin
            rst_q   <= 1'b0;
            cause   <= CAUSE_NONE;
            pending <= 1'b0;
         end
      end else begin
         irq <= ovf && !win_on && !pending;
         if (bad_clr) begin
            rst_q <= 1'b1;
            cause <= CAUSE_BADCLR;
         end else if (ovf && (win_on || pending)) begin
            rst_q <= 1'b1;
            cause <= CAUSE_OVF;
         end
         if (ok_clr) begin
            pending <= 1'b0;
         end else if (ovf && !win_on) begin
            pending <= 1'b1;
         end
      end
   end

   // R4: the interrupt lasts a single cycle
   p_irq_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   // R4: first overflow without window -> interrupt only
   p_first_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && ovf && !win_on && !pending && !rst_q) |=> (irq && !rst_q));

   // R5: second overflow -> overflow reset
   p_second_rst_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && ovf && !win_on && pending && !rst_q) |=> (rst_q && cause == CAUSE_OVF));

   // R8: windowed overflow resets without an interrupt
   p_win_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && ovf && win_on && !rst_q) |=> (rst_q && !irq && cause == CAUSE_OVF));

   // R9: request and cause held until acknowledge
   p_req_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (en && rst_q && !ack) |=> (rst_q && $stable(cause)));

   // R9: cause is non-zero exactly while requesting
   p_cause_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rst_q == (cause != CAUSE_NONE));

   // R10: disabled -> no interrupt and no request
   p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!irq && !rst_q));

endmodule

// File: rtl/watchdog_win.sv
module watchdog_win
   import wdt_pkg::*;
#(
   parameter int CNT_W = 18,
   parameter int NPER  = 8,
   parameter logic [NPER-1:0][4:0] PER_EXP =
      {5'd18, 5'd16, 5'd14, 5'd12, 5'd11, 5'd10, 5'd9, 5'd8},
   parameter bit THR_TABLE = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wd_en,
   input  logic                     tick,
   input  logic                     clr_req,
   input  logic [$clog2(NPER)-1:0]  period_sel,
   input  logic                     win_on,
   input  logic                     win_size,
   input  logic                     rst_ack,
   output logic                     irq,
   output logic                     rst_req,
   output logic [1:0]               rst_cause,
   output logic [CNT_W-1:0]         count
);

   localparam int SEL_W = $clog2(NPER);

   if ((1 << SEL_W) != NPER) begin : g_bad_nper
      $error("NPER must be a power of two");
   end
   for (genvar i = 0; i < NPER; i++) begin : g_chk_exp
      if (PER_EXP[i] > CNT_W || PER_EXP[i] < 2) begin : g_bad_exp
         $error("period exponent out of range for counter width");
      end
   end

   logic       wrap;
   logic       ok_clr;
   logic       bad_clr;
   logic       ovf;
   logic       restart;
   logic       hold;
   wdt_cause_e cause;

   assign ovf       = wrap && !ok_clr;
   assign rst_cause = cause;

   wdt_count #(
      .CNT_W   (CNT_W),
      .NPER    (NPER),
      .PER_EXP (PER_EXP)
   ) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (wd_en),
      .tick    (tick),
      .sel     (period_sel),
      .clr     (ok_clr || bad_clr),
      .hold    (hold),
      .restart (restart),
      .count   (count),
      .wrap    (wrap)
   );

   wdt_window #(
      .CNT_W     (CNT_W),
      .NPER      (NPER),
      .PER_EXP   (PER_EXP),
      .THR_TABLE (THR_TABLE)
   ) u_window (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (period_sel),
      .win_on   (win_on),
      .win_size (win_size),
      .en       (wd_en),
      .hold     (hold),
      .clr_req  (clr_req),
      .count    (count),
      .ok_clr   (ok_clr),
      .bad_clr  (bad_clr)
   );

   wdt_escal u_escal (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (wd_en),
      .ovf     (ovf),
      .ok_clr  (ok_clr),
      .bad_clr (bad_clr),
      .win_on  (win_on),
      .ack     (rst_ack),
      .irq     (irq),
      .rst_q   (rst_req),
      .cause   (cause),
      .restart (restart)
   );

   assign hold = rst_req;

   // R7: an early clear becomes an invalid-clear request
   p_bad_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bad_clr |=> (rst_req && rst_cause == 2'b10 && count == '0));

   // R11: a clear on the terminal tick suppresses the overflow
   p_clear_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && ok_clr) |=> (!irq && !rst_req && count == '0));

   // R9: acknowledge restarts the counter from zero
   p_ack_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_en && rst_req && rst_ack) |=> (!rst_req && count == '0));

endmodule

// File: tb/watchdog_win_bench.sv
`timescale 1ns/1ps
module watchdog_win_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wd_en = 1'b1;
   logic        tick = 1'b0;
   logic        clr_req = 1'b0;
   logic [2:0]  period_sel = 3'd0;
   logic        win_on = 1'b0;
   logic        win_size = 1'b0;
   logic        rst_ack = 1'b0;
   logic        irq;
   logic        rst_req;
   logic [1:0]  rst_cause;
   logic [17:0] count;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   watchdog_win u_watchdog_win (
      .clk        (clk),
      .rst_n      (rst_n),
      .wd_en      (wd_en),
      .tick       (tick),
      .clr_req    (clr_req),
      .period_sel (period_sel),
      .win_on     (win_on),
      .win_size   (win_size),
      .rst_ack    (rst_ack),
      .irq        (irq),
      .rst_req    (rst_req),
      .rst_cause  (rst_cause),
      .count      (count)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset(input logic [2:0] sel, input logic won, input logic wsz,
                           input logic en, input logic tk);
      @(negedge clk);
      rst_n = 1'b0;
      period_sel = sel; win_on = won; win_size = wsz; wd_en = en; tick = tk;
      clr_req = 1'b0; rst_ack = 1'b0;
      cyc(2);
      rst_n = 1'b1;
   endtask

   task automatic pulse_clr();
      clr_req = 1'b1; cyc(1); clr_req = 1'b0;
   endtask

   task automatic pulse_ack();
      rst_ack = 1'b1; cyc(1); rst_ack = 1'b0;
   endtask

   task automatic t_reset_state();
      do_reset(3'd0, 1'b0, 1'b0, 1'b1, 1'b0);
      chk("R1 count", count, 0);
      chk("R1 irq", irq, 0);
      chk("R1 rst_req", rst_req, 0);
      chk("R1 cause", rst_cause, 0);
   endtask

   task automatic t_count_hold();
      do_reset(3'd0, 1'b0, 1'b0, 1'b1, 1'b0);
      cyc(5);
      chk("R2 idle", count, 0);
      tick = 1'b1; cyc(10);
      chk("R2 ten ticks", count, 10);
      tick = 1'b0; cyc(3);
      chk("R2 hold", count, 10);
      for (int i = 0; i < 10; i++) begin
         tick = (i % 2 == 0); cyc(1);
      end
      chk("R2 sparse ticks", count, 15);
   endtask

   task automatic t_period(input logic [2:0] sel, input int len);
      do_reset(sel, 1'b0, 1'b0, 1'b1, 1'b1);
      cyc(len - 1);
      chk("R3 before end", count, len - 1);
      chk("R3 no early irq", irq, 0);
      cyc(1);
      chk("R3 wrap", count, 0);
      chk("R3 irq at end", irq, 1);
   endtask

   task automatic t_escalate();
      do_reset(3'd0, 1'b0, 1'b0, 1'b1, 1'b1);
      cyc(256);
      chk("R4 irq", irq, 1);
      chk("R4 no reset", rst_req, 0);
      cyc(1);
      chk("R4 pulse end", irq, 0);
      chk("R4 continues", count, 1);
      cyc(255);
      chk("R5 reset", rst_req, 1);
      chk("R5 cause", rst_cause, 1);
      chk("R5 no irq", irq, 0);
      cyc(20);
      chk("R9 held", rst_req, 1);
      chk("R9 cause held", rst_cause, 1);
      chk("R9 frozen", count, 0);
      pulse_clr();
      chk("R9 clear ignored", rst_req, 1);
      chk("R9 count after clear", count, 0);
      pulse_ack();
      chk("R9 released", rst_req, 0);
      chk("R9 cause none", rst_cause, 0);
      chk("R9 restart", count, 0);
      cyc(1);
      chk("R9 counting", count, 1);
   endtask

   task automatic t_clear();
      do_reset(3'd0, 1'b0, 1'b0, 1'b1, 1'b1);
      cyc(3);
      pulse_clr();
      chk("R6 early clear ok with window off", rst_req, 0);
      chk("R6 zeroed", count, 0);
      cyc(256);
      chk("R6 first irq", irq, 1);
      cyc(99);
      pulse_clr();
      chk("R6 clear zeroes", count, 0);
      chk("R6 no reset", rst_req, 0);
      cyc(256);
      chk("R6 pending dropped irq", irq, 1);
      chk("R6 pending dropped rst", rst_req, 0);
   endtask

   task automatic t_window(input logic wsz, input int thr);
      do_reset(3'd0, 1'b1, wsz, 1'b1, 1'b1);
      cyc(thr - 1);
      pulse_clr();
      chk("R7 early reset", rst_req, 1);
      chk("R7 early cause", rst_cause, 2);
      chk("R7 count zero", count, 0);
      pulse_ack();
      chk("R7 ack", rst_req, 0);
      do_reset(3'd0, 1'b1, wsz, 1'b1, 1'b1);
      cyc(thr);
      pulse_clr();
      chk("R7 at threshold ok", rst_req, 0);
      chk("R7 at threshold zero", count, 0);
   endtask

   task automatic t_window_ovf();
      do_reset(3'd0, 1'b1, 1'b1, 1'b1, 1'b1);
      cyc(255);
      chk("R8 before", rst_req, 0);
      cyc(1);
      chk("R8 direct reset", rst_req, 1);
      chk("R8 cause", rst_cause, 1);
      chk("R8 no irq", irq, 0);
   endtask

   task automatic t_disabled();
      do_reset(3'd0, 1'b0, 1'b0, 1'b0, 1'b1);
      cyc(300);
      chk("R10 count", count, 0);
      chk("R10 irq", irq, 0);
      chk("R10 rst", rst_req, 0);
      win_on = 1'b1;
      pulse_clr();
      chk("R10 clear ignored", rst_req, 0);
      chk("R10 cause", rst_cause, 0);
      win_on = 1'b0;
      wd_en = 1'b1; cyc(5);
      chk("R10 re-enabled", count, 5);
   endtask

   task automatic t_clear_at_end();
      do_reset(3'd0, 1'b0, 1'b0, 1'b1, 1'b1);
      cyc(256);
      chk("R11 pending set", irq, 1);
      cyc(255);
      chk("R11 at last", count, 255);
      pulse_clr();
      chk("R11 count", count, 0);
      chk("R11 no irq", irq, 0);
      chk("R11 no reset", rst_req, 0);
      cyc(256);
      chk("R11 next irq", irq, 1);
      chk("R11 next no reset", rst_req, 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      t_reset_state();
      t_count_hold();
      t_period(3'd0, 256);
      t_period(3'd1, 512);
      t_period(3'd2, 1024);
      t_period(3'd5, 16384);
      t_escalate();
      t_clear();
      t_window(1'b0, 128);
      t_window(1'b1, 64);
      t_window_ovf();
      t_disabled();
      t_clear_at_end();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule